// File: doc/BRIEF.md
# Double-Width Funnel Shifter

This block shifts a 16- or 32-bit operand left or right by a count of 0 to 31. The positions the shift empties are not filled with zeros or sign copies. They are filled with bits taken from a second operand, so a wider value held across several words can be shifted one word at a time. Along with the shifted word, the block produces carry, overflow, sign, zero, parity and auxiliary status flags. It also flags counts that do not fit the selected operand size.

A caller presents the operands, the count, the direction, the size and the current flag values, then pulses `start` for one cycle. On the next clock edge the block registers the result and flags and raises `done` for one cycle. Between operations the outputs hold their last values.

Flag vector layout, used on both `flags_in` and `flags_out`:

| Bit | Flag |
|---|---|
| 0 | carry |
| 1 | parity |
| 2 | auxiliary |
| 3 | zero |
| 4 | sign |
| 5 | overflow |

Top module: `fsh_funnel`

## Requirements
- R1: Only `count[4:0]` sets the shift distance. `count[7:5]` has no effect on any output.
- R2: When the count is 0, the result is the destination operand (limited to the selected size) and `flags_out` equals `flags_in`.
- R3: When `dir_right`=0 and the count c is between 1 and W-1, the result is the destination moved up by c, with the low c bits filled from the top c bits of the source. W is the operand width.
- R4: When `dir_right`=1 and the count c is between 1 and W-1, the result is the destination moved down by c, with the high c bits filled from the low c bits of the source.
- R5: For a valid nonzero count, carry (bit 0) is destination bit W-c for a left shift and destination bit c-1 for a right shift.
- R6: Overflow (bit 5) is set for a count of 1 when the result's top bit differs from the destination's top bit, and cleared otherwise. It is 0 for valid counts greater than 1.
- R7: For a valid nonzero count, sign (bit 4) is the result's top bit and zero (bit 3) is set when the result is all zeros. Parity (bit 1) is set when the low 8 result bits hold an even number of ones.
- R8: Auxiliary (bit 2) is 0 after any valid nonzero shift.
- R9: When the count is greater than or equal to W, `invalid` is 1, the result is 0 and `flags_out` equals `flags_in`. Otherwise `invalid` is 0.
- R10: `size32`=0 selects W=16 and `size32`=1 selects W=32. In 16-bit mode, result bits 31:16 are always 0.
- R11: Result, flags and `invalid` update on the clock edge where `start` is high, and `done` is high for exactly the following cycle. Without `start`, the outputs hold their values.
- R12: After reset, result, flags, `invalid` and `done` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begins an operation this cycle |
| dir_right | input | 1 | 0 = shift left, 1 = shift right |
| size32 | input | 1 | 0 = 16-bit operands, 1 = 32-bit operands |
| count | input | 8 | Shift count; only the low 5 bits are used |
| dst | input | 32 | Operand to be shifted |
| src | input | 32 | Operand that supplies the fill bits |
| flags_in | input | 6 | Current flag values, kept for a zero or invalid count |
| result | output | 32 | Registered shifted word |
| flags_out | output | 6 | Registered flag values |
| invalid | output | 1 | Count was at or above the operand width |
| done | output | 1 | One-cycle pulse marking new outputs |

## Verification
Two situations are hard to reach from the ports. The first is a 5-bit count that lands at or beyond the operand width, which only happens in 16-bit mode. The second is a count value that hides nonzero bits above the five that are used. The stimulus sweeps every count from 0 to 31 in both sizes and both directions, and sets the ignored upper count bits to a different pattern for each operand pair. This drives every zero, valid, boundary (W-1 and W) and invalid count through both fill directions. The operand pairs are chosen so that sign changes, all-zero results and both parities of the low byte each occur.

// File: rtl/fsh_pkg.sv
package fsh_pkg;

    // Status flags; the member order fixes the bit positions (carry is bit 0).
    typedef struct packed {
        logic ovf;
        logic sgn;
        logic zro;
        logic aux;
        logic par;
        logic cry;
    } fsh_flags_t;

    localparam int FSH_FLAG_W = $bits(fsh_flags_t);

    // Set when the byte has an even number of ones.
    function automatic logic even_ones(input logic [7:0] b);
        return ~^b;
    endfunction

endpackage

// File: rtl/fsh_lanes.sv
module fsh_lanes #(
    parameter int DW    = 32,
    parameter int CNT_W = 5
) (
    input  logic             dir_right,
    input  logic [CNT_W-1:0] cnt,
    input  logic [DW-1:0]    dst,
    input  logic [DW-1:0]    src,
    output logic [DW-1:0]    res_half,
    output logic [DW-1:0]    res_full,
    output logic             cy_half,
    output logic             cy_full
);
    logic [1:0][DW-1:0] lane_res;
    logic [1:0]         lane_cy;

    // Lane 0 handles half-width operands, lane 1 full-width operands.
    for (genvar g = 0; g < 2; g++) begin : g_lane
        localparam int LW = (g == 0) ? DW / 2 : DW;
        logic [2*LW-1:0] up_cat;
        logic [2*LW-1:0] dn_cat;
        logic [LW-1:0]   up_res;
        logic [LW-1:0]   dn_res;
        logic            up_cy;
        logic            dn_cy;

        assign up_cat = {dst[LW-1:0], src[LW-1:0]};
        assign dn_cat = {src[LW-1:0], dst[LW-1:0]};
        assign up_res = LW'((up_cat << cnt) >> LW);
        assign dn_res = LW'(dn_cat >> cnt);
        assign up_cy  = 1'((up_cat << (cnt - 1'b1)) >> (2*LW - 1));
        assign dn_cy  = 1'(dn_cat >> (cnt - 1'b1));

        assign lane_res[g] = DW'(dir_right ? dn_res : up_res);
        assign lane_cy[g]  = dir_right ? dn_cy : up_cy;
    end

    assign res_half = lane_res[0];
    assign res_full = lane_res[1];
    assign cy_half  = lane_cy[0];
    assign cy_full  = lane_cy[1];
endmodule

// File: rtl/fsh_flag_gen.sv
module fsh_flag_gen
    import fsh_pkg::*;
#(
    parameter int DW    = 32,
    parameter int CNT_W = 5
) (
    input  logic             size32,
    input  logic [CNT_W-1:0] cnt,
    input  logic             bad_cnt,
    input  logic [DW-1:0]    dst,
    input  logic [DW-1:0]    res_half,
    input  logic [DW-1:0]    res_full,
    input  logic             cy_half,
    input  logic             cy_full,
    input  fsh_flags_t       fin,
    output logic [DW-1:0]    res_o,
    output fsh_flags_t       fout
);
    localparam int HW = DW / 2;

    logic [DW-1:0] pick;
    logic          pick_cy;
    logic          res_top;
    logic          dst_top;

    always_comb begin
        pick    = size32 ? res_full : res_half;
        pick_cy = size32 ? cy_full : cy_half;
        res_top = size32 ? res_full[DW-1] : res_half[HW-1];
        dst_top = size32 ? dst[DW-1] : dst[HW-1];
    end

    always_comb begin
        fout = fin;
        if (bad_cnt) begin
            res_o = '0;
        end else if (cnt == '0) begin
            res_o = size32 ? dst : {{(DW-HW){1'b0}}, dst[HW-1:0]};
        end else begin
            res_o    = pick;
            fout.cry = pick_cy;
            fout.ovf = (cnt == CNT_W'(1)) ? (res_top ^ dst_top) : 1'b0;
            fout.sgn = res_top;
            fout.zro = (pick == '0);
            fout.aux = 1'b0;
            fout.par = even_ones(pick[7:0]);
        end
    end
endmodule

// File: rtl/fsh_funnel.sv
module fsh_funnel
    import fsh_pkg::*;
#(
    parameter int DW       = 32,
    parameter int CNT_IN_W = 8
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  start,
    input  logic                  dir_right,
    input  logic                  size32,
    input  logic [CNT_IN_W-1:0]   count,
    input  logic [DW-1:0]         dst,
    input  logic [DW-1:0]         src,
    input  logic [FSH_FLAG_W-1:0] flags_in,
    output logic [DW-1:0]         result,
    output logic [FSH_FLAG_W-1:0] flags_out,
    output logic                  invalid,
    output logic                  done
);
    localparam int CNT_W = $clog2(DW);
    localparam int HW    = DW / 2;

    logic [CNT_W-1:0] eff_cnt;
    logic             unused_cnt_hi;
    logic [CNT_W:0]   width_lim;
    logic             bad_cnt;
    logic [DW-1:0]    res_half, res_full, res_next;
    logic             cy_half, cy_full;
    fsh_flags_t       fin, fnext, fq;

    assign eff_cnt       = count[CNT_W-1:0];
    assign unused_cnt_hi = ^count[CNT_IN_W-1:CNT_W];
    assign width_lim     = size32 ? (CNT_W+1)'(DW) : (CNT_W+1)'(HW);
    assign bad_cnt       = ({1'b0, eff_cnt} >= width_lim);
    assign fin           = fsh_flags_t'(flags_in);

    fsh_lanes #(.DW(DW), .CNT_W(CNT_W)) u_lanes (
        .dir_right (dir_right),
        .cnt       (eff_cnt),
        .dst       (dst),
        .src       (src),
        .res_half  (res_half),
        .res_full  (res_full),
        .cy_half   (cy_half),
        .cy_full   (cy_full)
    );

    fsh_flag_gen #(.DW(DW), .CNT_W(CNT_W)) u_flags (
        .size32   (size32),
        .cnt      (eff_cnt),
        .bad_cnt  (bad_cnt),
        .dst      (dst),
        .res_half (res_half),
        .res_full (res_full),
        .cy_half  (cy_half),
        .cy_full  (cy_full),
        .fin      (fin),
        .res_o    (res_next),
        .fout     (fnext)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            result  <= '0;
            fq      <= '0;
            invalid <= 1'b0;
            done    <= 1'b0;
        end else begin
            done <= start;
            if (start) begin
                result  <= res_next;
                fq      <= fnext;
                invalid <= bad_cnt;
            end
        end
    end

    assign flags_out = fq;

    // R11
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        start |=> done);

    // R11
    done_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !start |=> !done);

    // R11
    hold_out_chk: assert property (@(posedge clk) disable iff (rst)
        !start |=> ($stable(result) && $stable(flags_out) && $stable(invalid)));

    // R9
    bad_count_chk: assert property (@(posedge clk) disable iff (rst)
        (start && bad_cnt) |=> (invalid && result == '0 && flags_out == $past(flags_in)));

    // R2
    zero_count_chk: assert property (@(posedge clk) disable iff (rst)
        (start && eff_cnt == '0) |=> (!invalid && flags_out == $past(flags_in)));

    // R10
    half_upper_chk: assert property (@(posedge clk) disable iff (rst)
        (start && !size32) |=> (result[DW-1:HW] == '0));

    // R8
    aux_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (start && !bad_cnt && eff_cnt != '0) |=> !flags_out[2]);
endmodule

// File: tb/fsh_funnel_tb.sv
`timescale 1ns/1ps
module fsh_funnel_tb;
    logic        clk = 1'b0;
    logic        rst;
    logic        start;
    logic        dir_right;
    logic        size32;
    logic [7:0]  count;
    logic [31:0] dst, src;
    logic [5:0]  flags_in;
    logic [31:0] result;
    logic [5:0]  flags_out;
    logic        invalid;
    logic        done;

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    fsh_funnel u_dut (
        .clk(clk), .rst(rst), .start(start), .dir_right(dir_right),
        .size32(size32), .count(count), .dst(dst), .src(src),
        .flags_in(flags_in), .result(result), .flags_out(flags_out),
        .invalid(invalid), .done(done)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // Bit-by-bit reference built from the requirement text.
    task automatic model(input bit sz, input bit dr, input int c,
                         input logic [31:0] d, input logic [31:0] s,
                         input logic [5:0] fi,
                         output logic [31:0] r, output logic [5:0] f,
                         output bit inv);
        int w;
        int ones;
        w = sz ? 32 : 16;
        r = '0;
        f = fi;
        inv = 0;
        if (c >= w) begin
            inv = 1;
        end else if (c == 0) begin
            for (int i = 0; i < w; i++) r[i] = d[i];
        end else begin
            for (int i = 0; i < w; i++) begin
                if (!dr) r[i] = (i >= c) ? d[i-c] : s[w-c+i];
                else     r[i] = (i < w-c) ? d[i+c] : s[i+c-w];
            end
            f[0] = dr ? d[c-1] : d[w-c];
            f[5] = (c == 1) ? (r[w-1] ^ d[w-1]) : 1'b0;
            f[4] = r[w-1];
            f[3] = (r == 0);
            f[2] = 1'b0;
            ones = 0;
            for (int i = 0; i < 8; i++) ones += r[i];
            f[1] = (ones % 2 == 0);
        end
    endtask

    task automatic run_op(input bit sz, input bit dr, input logic [7:0] raw,
                          input logic [31:0] d, input logic [31:0] s,
                          input logic [5:0] fi);
        logic [31:0] er;
        logic [5:0]  ef;
        bit          einv;
        int          c;
        string       rq;
        logic [31:0] held_r;
        c = int'(raw[4:0]);
        model(sz, dr, c, d, s, fi, er, ef, einv);
        @(negedge clk);
        size32 = sz; dir_right = dr; count = raw; dst = d; src = s;
        flags_in = fi; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk("R11", "done", 32'(done), 32'd1);
        chk("R9", "invalid", 32'(invalid), 32'(einv));
        if (einv)          rq = "R9";
        else if (c == 0)   rq = "R2";
        else if (dr)       rq = "R4";
        else               rq = "R3";
        if (raw[7:5] != 3'd0) rq = {rq, "/R1"};
        chk(rq, "result", result, er);
        if (!sz) chk("R10", "upper", 32'(result[31:16]), 32'd0);
        if (einv || c == 0) begin
            chk(rq, "flags", 32'(flags_out), 32'(ef));
        end else begin
            chk("R5", "carry", 32'(flags_out[0]), 32'(ef[0]));
            chk("R6", "overflow", 32'(flags_out[5]), 32'(ef[5]));
            chk("R7", "sign", 32'(flags_out[4]), 32'(ef[4]));
            chk("R7", "zero", 32'(flags_out[3]), 32'(ef[3]));
            chk("R7", "parity", 32'(flags_out[1]), 32'(ef[1]));
            chk("R8", "aux", 32'(flags_out[2]), 32'(ef[2]));
        end
        held_r = result;
        dst = ~d; flags_in = ~fi;
        @(negedge clk);
        chk("R11", "done_low", 32'(done), 32'd0);
        chk("R11", "hold", result, held_r);
    endtask

    logic [31:0] pat_d [8];
    logic [31:0] pat_s [8];

    initial begin
        pat_d[0] = 32'h8000_0001; pat_s[0] = 32'h0000_0000;
        pat_d[1] = 32'hFFFF_FFFF; pat_s[1] = 32'h0000_0000;
        pat_d[2] = 32'h0000_0000; pat_s[2] = 32'h0000_0000;
        pat_d[3] = 32'h1234_5678; pat_s[3] = 32'h9ABC_DEF0;
        pat_d[4] = 32'h0000_8000; pat_s[4] = 32'h0000_FFFF;
        pat_d[5] = 32'h7FFF_7FFF; pat_s[5] = 32'h8000_8000;
        pat_d[6] = 32'hA5A5_A5A5; pat_s[6] = 32'h5A5A_5A5A;
        pat_d[7] = 32'h0000_0001; pat_s[7] = 32'hFFFF_0000;

        rst = 1'b1; start = 1'b0; dir_right = 1'b0; size32 = 1'b0;
        count = '0; dst = '0; src = '0; flags_in = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R12 reset state
        chk("R12", "result", result, 32'd0);
        chk("R12", "flags", 32'(flags_out), 32'd0);
        chk("R12", "invalid", 32'(invalid), 32'd0);
        chk("R12", "done", 32'(done), 32'd0);

        for (int p = 0; p < 8; p++)
            for (int sz = 0; sz < 2; sz++)
                for (int dr = 0; dr < 2; dr++)
                    for (int c = 0; c < 32; c++)
                        run_op(bit'(sz), bit'(dr), 8'(c) | 8'(p << 5),
                               pat_d[p], pat_s[p], 6'(p * 11 + c) ^ 6'h2A);

        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule